// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a memory-mapped watchdog with two escalation stages. It runs from a free-running 64-bit system counter supplied as an input. Software programs a timeout period into an offset register and turns the timer on. After that it must write to the refresh frame before the system counter reaches the stored 64-bit compare value. If software misses that deadline, the first-stage output goes high and the compare value moves one offset period further on. If that second deadline also passes without a refresh, the second-stage output goes high. The first stage normally raises an interrupt. The second stage normally triggers a system reset.

The register space has two frames. A frame-select input picks between them. Any write to the refresh frame restarts the timeout. The control frame holds these registers:

- an enable and status word;
- the offset period;
- the compare value, as two 32-bit words;
- a read-only identification word that reports the architecture version.

The parameter `VERSION` chooses the width of the offset period. Version 0 gives 32 bits and version 1 gives 48 bits. All other behaviour is identical between the two versions.

Top module: `twdog_top`

## Requirements
- R1: After reset the enable bit, both stage flags and both stage outputs are 0, and the compare value and offset registers read 0.
- R2: Bit 0 of the control word at byte offset 0x000 is the enable. While it is 0 neither stage output can rise, and the flags keep their values. Once it is 1, an expired compare value takes effect on the following clock edge.
- R3: When the timer is enabled, the counter is at or above the compare value and the first-stage flag is clear, the first-stage flag sets on that clock edge. On the same edge the compare value becomes the counter plus the offset.
- R4: When the timer is enabled, the counter is at or above the compare value and the first-stage flag is already set, the second-stage flag sets.
- R5: A write to the refresh frame (frame select 1, any address, any data) clears both flags. It also loads the compare value with the counter plus the offset.
- R6: A write to an implemented offset word clears both flags. It also loads the compare value with the counter plus the new offset.
- R7: The control word reports the first-stage flag in bit 1 and the second-stage flag in bit 2. Writes to those two bits have no effect.
- R8: The identification word at byte offset 0xFCC carries the architecture version in bits [19:16].
- R9: With version 0 the offset is 32 bits at byte offset 0x008. The word at 0x00C reads 0, and a write to it has no effect of any kind.
- R10: With version 1 the offset is 48 bits, split across 0x008 (bits 31:0) and 0x00C (bits 47:32). Bits [31:16] of the word at 0x00C read 0 and ignore writes.
- R11: The 64-bit compare value can be read and written as a low word at 0x010 and a high word at 0x014.
- R12: A refresh write in the same cycle as an expiry takes priority: both flags end up clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_cnt | input | 64 | Free-running system counter value |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_frame | input | 1 | Frame select: 0 control frame, 1 refresh frame |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed control-frame word (combinational) |
| stage1_out | output | 1 | First-stage timeout signal |
| stage2_out | output | 1 | Second-stage timeout signal |

## Verification
Every register update and flag change takes effect on the first rising edge after the write or the counter crossing is presented, so each result is due exactly one clock edge after its stimulus. Read data is combinational from the registered state, so a read returns a value in the same cycle its address is driven. The bench changes the counter and the bus on falling edges and samples results on the next falling edge, one rising edge later. Both versions are instantiated side by side with identical stimulus, so width-dependent differences appear as diverging expected values.

// File: rtl/twdog_pkg.sv
package twdog_pkg;

    localparam int CNT_W  = 64;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] A_OFS_LO = 12'h008;
    localparam logic [ADDR_W-1:0] A_OFS_HI = 12'h00C;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h010;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 12'h014;
    localparam logic [ADDR_W-1:0] A_IDENT  = 12'hFCC;

    typedef struct packed {
        logic             en;
        logic             ws0;
        logic             ws1;
        logic [CNT_W-1:0] ofs;
        logic [CNT_W-1:0] cmp;
    } wd_state_t;

    typedef struct packed {
        logic ctrl;
        logic ofs_lo;
        logic ofs_hi;
        logic cmp_lo;
        logic cmp_hi;
        logic refresh;
    } wd_wstrb_t;

    function automatic int ofs_width(input int ver);
        return (ver == 1) ? 48 : 32;
    endfunction

endpackage

// File: rtl/twdog_regdec.sv
module twdog_regdec
    import twdog_pkg::*;
#(
    parameter bit HAS_OFS_HI = 1'b1
) (
    input  logic              bus_wr,
    input  logic              bus_frame,
    input  logic [ADDR_W-1:0] bus_addr,
    output wd_wstrb_t         wstrb
);

    logic cwr;
    assign cwr = bus_wr && !bus_frame;

    assign wstrb.ctrl    = cwr && (bus_addr == A_CTRL);
    assign wstrb.ofs_lo  = cwr && (bus_addr == A_OFS_LO);
    assign wstrb.cmp_lo  = cwr && (bus_addr == A_CMP_LO);
    assign wstrb.cmp_hi  = cwr && (bus_addr == A_CMP_HI);
    assign wstrb.refresh = bus_wr && bus_frame;

    generate
        if (HAS_OFS_HI) begin : g_hi
            assign wstrb.ofs_hi = cwr && (bus_addr == A_OFS_HI);
        end else begin : g_nohi
            assign wstrb.ofs_hi = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/twdog_cmp.sv
module twdog_cmp
    import twdog_pkg::*;
(
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             hit
);

    assign hit = en && (cnt >= cmp);

endmodule

// File: rtl/twdog_rdmux.sv
module twdog_rdmux
    import twdog_pkg::*;
#(
    parameter int          VERSION    = 1,
    parameter logic [15:0] IDENT_CODE = 16'h0A5D
) (
    input  logic              bus_frame,
    input  logic [ADDR_W-1:0] bus_addr,
    input  wd_state_t         st,
    output logic [WORD_W-1:0] rdata
);

    localparam logic [3:0] VER4 = 4'(VERSION);

    always_comb begin
        rdata = '0;
        if (!bus_frame) begin
            case (bus_addr)
                A_CTRL:   rdata = {29'h0, st.ws1, st.ws0, st.en};
                A_OFS_LO: rdata = st.ofs[31:0];
                A_OFS_HI: rdata = st.ofs[63:32];
                A_CMP_LO: rdata = st.cmp[31:0];
                A_CMP_HI: rdata = st.cmp[63:32];
                A_IDENT:  rdata = {12'h000, VER4, IDENT_CODE};
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/twdog_top.sv
module twdog_top
    import twdog_pkg::*;
#(
    parameter int          VERSION    = 1,
    parameter logic [15:0] IDENT_CODE = 16'h0A5D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       sys_cnt,
    input  logic              bus_wr,
    input  logic              bus_frame,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              stage1_out,
    output logic              stage2_out
);

    localparam int               OFS_W      = ofs_width(VERSION);
    localparam logic [CNT_W-1:0] OFS_MASK   = (64'd1 << OFS_W) - 64'd1;
    localparam bit               HAS_OFS_HI = (OFS_W > WORD_W);

    wd_state_t        st_d, st_q;
    wd_wstrb_t        wstrb;
    logic             hit;
    logic             reload;
    logic [CNT_W-1:0] ofs_new;
    logic             en_q;

    twdog_regdec #(.HAS_OFS_HI(HAS_OFS_HI)) u_dec (
        .bus_wr    (bus_wr),
        .bus_frame (bus_frame),
        .bus_addr  (bus_addr),
        .wstrb     (wstrb)
    );

    twdog_cmp u_cmp (
        .en  (st_q.en),
        .cnt (sys_cnt),
        .cmp (st_q.cmp),
        .hit (hit)
    );

    twdog_rdmux #(.VERSION(VERSION), .IDENT_CODE(IDENT_CODE)) u_rd (
        .bus_frame (bus_frame),
        .bus_addr  (bus_addr),
        .st        (st_q),
        .rdata     (bus_rdata)
    );

    always_comb begin
        st_d    = st_q;
        ofs_new = st_q.ofs;
        if (wstrb.ofs_lo) ofs_new[31:0]  = bus_wdata;
        if (wstrb.ofs_hi) ofs_new[63:32] = bus_wdata;
        ofs_new  = ofs_new & OFS_MASK;
        st_d.ofs = ofs_new;
        reload   = wstrb.refresh || wstrb.ofs_lo || wstrb.ofs_hi;

        if (wstrb.ctrl)   st_d.en         = bus_wdata[0];
        if (wstrb.cmp_lo) st_d.cmp[31:0]  = bus_wdata;
        if (wstrb.cmp_hi) st_d.cmp[63:32] = bus_wdata;

        if (reload) begin
            st_d.ws0 = 1'b0;
            st_d.ws1 = 1'b0;
            st_d.cmp = sys_cnt + ofs_new;
        end else if (hit) begin
            if (!st_q.ws0) begin
                st_d.ws0 = 1'b1;
                st_d.cmp = sys_cnt + st_q.ofs;
            end else begin
                st_d.ws1 = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q       = st_q.en;
    assign stage1_out = st_q.ws0;
    assign stage2_out = st_q.ws1;

endmodule

// File: rtl/twdog_chk.sv
module twdog_chk #(
    parameter int VERSION = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_frame,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_rdata,
    input logic        stage1_out,
    input logic        stage2_out,
    input logic        en_q
);

    // R5 / R12: refresh always leaves both flags clear
    a_r5_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_frame) |=> (!stage1_out && !stage2_out));

    // R4: second stage only follows an already set first stage
    a_r4_stage2_after_stage1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage2_out) |-> $past(stage1_out));

    // R2: nothing rises while disabled
    a_r2_s1_held_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !stage1_out) |=> !stage1_out);

    a_r2_s2_held_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !stage2_out) |=> !stage2_out);

    // R3: first stage rises only from an enabled timer
    a_r3_s1_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage1_out) |-> $past(en_q));

    // R8: version field
    a_r8_ident_ver: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_frame && bus_addr == 12'hFCC) |-> (bus_rdata[19:16] == 4'(VERSION)));

    // R9 / R10: reserved bits of the upper offset word
    a_r10_ofs_hi_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_frame && bus_addr == 12'h00C) |->
            ((VERSION == 1) ? (bus_rdata[31:16] == 16'h0) : (bus_rdata == 32'h0)));

endmodule

bind twdog_top twdog_chk #(.VERSION(VERSION)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_frame  (bus_frame),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .stage1_out (stage1_out),
    .stage2_out (stage2_out),
    .en_q       (en_q)
);

// File: tb/twdog_top_tb.sv
module twdog_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_cnt = '0;
    logic        bus_wr = 1'b0;
    logic        bus_frame = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd1, rd0;
    logic        s1_v1, s2_v1, s1_v0, s2_v0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    twdog_top #(.VERSION(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .bus_wr(bus_wr),
        .bus_frame(bus_frame), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd1), .stage1_out(s1_v1), .stage2_out(s2_v1)
    );

    twdog_top #(.VERSION(0)) u_dut_v0 (
        .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .bus_wr(bus_wr),
        .bus_frame(bus_frame), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd0), .stage1_out(s1_v0), .stage2_out(s2_v0)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic frame, input logic [11:0] addr, input logic [31:0] data);
        bus_wr = 1'b1; bus_frame = frame; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0; bus_frame = 1'b0;
    endtask

    task automatic rd(input logic [11:0] addr);
        bus_frame = 1'b0; bus_addr = addr;
        #1;
    endtask

    task automatic tick(input logic [63:0] v);
        sys_cnt = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rd(12'h000); chk("R1 v1 ctrl", rd1, 0); chk("R1 v0 ctrl", rd0, 0);
        rd(12'h010); chk("R1 v1 cmp", rd1, 0);
        rd(12'h008); chk("R1 v0 ofs", rd0, 0);
        chk("R1 stages", {s1_v1, s2_v1, s1_v0, s2_v0}, 0);
    endtask

    task automatic t_ident;
        rd(12'hFCC);
        chk("R8 v1 version", rd1[19:16], 1);
        chk("R8 v0 version", rd0[19:16], 0);
    endtask

    task automatic t_ofs_mask;
        wr(1'b0, 12'h008, 32'h1234_5678);
        wr(1'b0, 12'h00C, 32'hABCD_9876);
        rd(12'h008); chk("R10 v1 ofs lo", rd1, 32'h1234_5678); chk("R9 v0 ofs lo", rd0, 32'h1234_5678);
        rd(12'h00C); chk("R10 v1 ofs hi masked", rd1, 32'h0000_9876); chk("R9 v0 ofs hi zero", rd0, 0);
    endtask

    task automatic t_stages;
        sys_cnt = 64'd1000;
        wr(1'b0, 12'h008, 32'd100);
        wr(1'b0, 12'h00C, 32'd0);
        rd(12'h010); chk("R6 v1 cmp", rd1, 1100); chk("R6 v0 cmp", rd0, 1100);
        rd(12'h014); chk("R6 v1 cmp hi", rd1, 0);
        wr(1'b0, 12'h000, 32'h1);
        tick(64'd1099);
        chk("R3 no early stage1", {s1_v1, s1_v0}, 2'b00);
        tick(64'd1100);
        chk("R3 stage1 both", {s1_v1, s1_v0}, 2'b11);
        rd(12'h000); chk("R7 ctrl ws0 bit1", rd1, 3);
        rd(12'h010); chk("R3 cmp reload", rd1, 1200);
        tick(64'd1199);
        chk("R4 no early stage2", {s2_v1, s2_v0}, 2'b00);
        tick(64'd1200);
        chk("R4 stage2 both", {s2_v1, s2_v0}, 2'b11);
        rd(12'h000); chk("R7 ctrl ws1 bit2", rd0, 7);
    endtask

    task automatic t_refresh;
        sys_cnt = 64'd5000;
        wr(1'b1, 12'h000, 32'h0);
        chk("R5 flags cleared", {s1_v1, s2_v1, s1_v0, s2_v0}, 0);
        rd(12'h000); chk("R5 ctrl", rd1, 1);
        rd(12'h010); chk("R5 cmp reload", rd0, 5100);
    endtask

    task automatic t_disable;
        wr(1'b0, 12'h000, 32'h6);
        rd(12'h000); chk("R7 status bits ignore writes", rd1, 0);
        tick(64'd6000);
        tick(64'd6000);
        chk("R2 held off while disabled", {s1_v1, s1_v0}, 2'b00);
        wr(1'b0, 12'h000, 32'h1);
        tick(64'd6000);
        chk("R2 fires once enabled", {s1_v1, s1_v0}, 2'b11);
        rd(12'h010); chk("R2 cmp reload", rd1, 6100);
    endtask

    task automatic t_priority;
        sys_cnt = 64'd10000;
        wr(1'b1, 12'h000, 32'h0);
        chk("R12 refresh wins", {s1_v1, s2_v1, s1_v0, s2_v0}, 0);
        rd(12'h010); chk("R12 cmp", rd1, 10100);
    endtask

    task automatic t_wide;
        wr(1'b0, 12'h00C, 32'h1);
        rd(12'h014); chk("R10 v1 cmp hi", rd1, 1); chk("R9 v0 cmp hi untouched", rd0, 0);
        rd(12'h010); chk("R10 v1 cmp lo", rd1, 10100);
        tick(64'd20000);
        chk("R10 v1 wide offset no fire", s1_v1, 0);
        chk("R9 v0 fires", s1_v0, 1);
    endtask

    task automatic t_cmp_access;
        wr(1'b0, 12'h000, 32'h0);
        wr(1'b0, 12'h014, 32'h0);
        wr(1'b0, 12'h010, 32'd30000);
        rd(12'h010); chk("R11 cmp lo v1", rd1, 30000); chk("R11 cmp lo v0", rd0, 30000);
        rd(12'h014); chk("R11 cmp hi v1", rd1, 0);
        wr(1'b0, 12'h000, 32'h1);
        tick(64'd29999);
        chk("R11 before compare", {s1_v1, s2_v0}, 2'b00);
        tick(64'd30000);
        chk("R11 v1 stage1 at compare", s1_v1, 1);
        chk("R4 v0 stage2 at compare", s2_v0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_ofs_mask();
        t_stages();
        t_refresh();
        t_disable();
        t_priority();
        t_wide();
        t_cmp_access();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule